// File: doc/BRIEF.md
# Strobed Parallel Port with Two-Step Flag Clear

This block is an 8-bit parallel port. A CPU drives it through a small register bus with an address, a read strobe, a write strobe and write/read data. There are three registers: the port data register, the direction register and the handshake control/status register.

With every direction bit at one, the port works as an output port. A data write stores a byte that drives the pins, and a data read returns that stored byte. With every direction bit at zero, the port works as a strobed input port. An active-low strobe pin is brought onto the system clock through a synchroniser. Each falling edge of the strobe captures the synchronised pin byte into a latch and raises a sticky strobe flag. The flag can request an interrupt. In this mode, data writes land in a separate byte that drives eight pull-up enable outputs.

Software acknowledges a strobe in two steps. It first reads the status register while the flag is set, and then it reads or writes the data register. Until the flag is cleared, data reads in input mode return the captured byte. Once the flag is clear, they return the live pins.

Top module: `hsp_port`

## Requirements
- R1: After reset the status register reads 0x03, the direction register reads 0x00, `irq` is 0, `pin_oe` is 0x00 and `pullup_en` is 0x00.
- R2: Status register layout: bit 7 is the strobe flag and software writes do not change it. Bits 6..2 are control bits that read back what was last written to them, and bit 6 is the interrupt enable. Bits 1..0 always read 1. Register offsets are: data at 0, direction at 1, status at 2. Offset 3 reads 0.
- R3: A falling edge on `strobe_n` sets the strobe flag. The strobe passes through two synchroniser flops and one edge register, so the flag becomes visible three clock edges after `strobe_n` is first sampled low.
- R4: On that falling edge, the latch captures the pin byte. The pins are synchronised with the same delay as the strobe.
- R5: The flag is cleared by a read or write of offset 0 that comes after a read of offset 2 made while the flag was 1.
- R6: A data register access with no status read since the flag was set leaves the flag at 1.
- R7: For each bit whose direction bit is 1, a data write sets `pin_out` and a data read returns the stored value. `pin_oe` equals the direction register.
- R8: For each bit whose direction bit is 0, a data write goes to the pull-up latch and leaves `pin_out` unchanged. `pullup_en` shows that latch for those bits and 0 for output bits.
- R9: For each bit whose direction bit is 0, a data read returns the captured byte while the flag is 1, and the synchronised live pins while it is 0.
- R10: `irq` is 1 exactly while the strobe flag and the interrupt enable bit (status bit 6) are both 1.
- R11: If a strobe falling edge lands in the same cycle as a clearing data access, the flag stays set, the new byte is captured and the pending clear is cancelled. A further data access then does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset |
| rd | input | 1 | Read strobe for one cycle |
| wr | input | 1 | Write strobe for one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, combinational |
| pin_in | input | DW | Port pin input levels |
| strobe_n | input | 1 | Asynchronous active-low input strobe |
| pin_out | output | DW | Port output data |
| pin_oe | output | DW | Per-bit output enable |
| pullup_en | output | DW | Per-bit pull-up enable |
| irq | output | 1 | Strobe interrupt request |

## Verification
The bench builds the port with DW = 8 and SYNC_STAGES = 2. With these values, the latency from the strobe pin to the flag is a fixed three edges. This lets the bench place a new strobe edge in exactly the cycle of a clearing data access, so the R11 collision is exercised deliberately rather than by chance. An 8-bit port spans the whole data bus, so both the captured byte and the live pin byte can be told apart by value in every bit position.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
   localparam int BUS_W  = 8;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_DATA = 2'd0,
      REG_DIR  = 2'd1,
      REG_HCS  = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   localparam int CTL_LO = 2;
   localparam int CTL_HI = 6;
   localparam int CTL_W  = CTL_HI - CTL_LO + 1;
   localparam int IE_IDX = 6 - CTL_LO;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
   parameter int   W       = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_BIT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsp_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= {W{RST_BIT}};
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hsp_flag.sv
module hsp_flag #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fall,
   input  logic          stat_rd,
   input  logic          data_acc,
   input  logic [DW-1:0] live,
   output logic          flag,
   output logic [DW-1:0] latched
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         armed   <= 1'b0;
         latched <= '0;
      end else if (fall) begin
         flag    <= 1'b1;
         armed   <= 1'b0;
         latched <= live;
      end else if (armed && flag && data_acc) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else if (stat_rd && flag) begin
         armed <= 1'b1;
      end
   end

   p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> flag);
   p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(fall));
   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> latched == $past(live));
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      armed && flag && data_acc && !fall |=> !flag);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !armed && !fall |=> flag);
   p_collide_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fall && armed && data_acc |=> flag && !armed);
endmodule

// File: rtl/hsp_port.sv
module hsp_port import hsp_pkg::*; #(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic [DW-1:0]     pin_in,
   input  logic              strobe_n,
   output logic [DW-1:0]     pin_out,
   output logic [DW-1:0]     pin_oe,
   output logic [DW-1:0]     pullup_en,
   output logic              irq
);
   generate
      if (DW < 1 || DW > BUS_W) begin : g_bad_dw
         $error("hsp_port: DW must lie in 1..BUS_W");
      end
   endgenerate

   reg_sel_e         sel;
   logic [DW-1:0]    dir_q, out_q, pu_q;
   logic [CTL_W-1:0] ctl_q;
   logic             stb_s, stb_prev, fall;
   logic [DW-1:0]    pin_s, latched, in_view, data_view;
   logic             flag, data_acc, stat_rd;

   assign sel = reg_sel_e'(addr);

   hsp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_BIT(1'b1)) u_stb_sync (
      .clk(clk), .rst_n(rst_n), .d(strobe_n), .q(stb_s));

   hsp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_BIT(1'b0)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_prev <= 1'b1;
      else        stb_prev <= stb_s;
   end

   assign fall     = stb_prev & ~stb_s;
   assign data_acc = (sel == REG_DATA) && (rd || wr);
   assign stat_rd  = (sel == REG_HCS) && rd;

   hsp_flag #(.DW(DW)) u_flag (
      .clk(clk), .rst_n(rst_n), .fall(fall), .stat_rd(stat_rd),
      .data_acc(data_acc), .live(pin_s), .flag(flag), .latched(latched));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
         pu_q  <= '0;
         ctl_q <= '0;
      end else if (wr) begin
         case (sel)
            REG_DATA: begin
               out_q <= (out_q & ~dir_q) | (wdata[DW-1:0] & dir_q);
               pu_q  <= (pu_q & dir_q) | (wdata[DW-1:0] & ~dir_q);
            end
            REG_DIR: dir_q <= wdata[DW-1:0];
            REG_HCS: ctl_q <= wdata[CTL_HI:CTL_LO];
            default: ;
         endcase
      end
   end

   assign in_view   = flag ? latched : pin_s;
   assign data_view = (dir_q & out_q) | (~dir_q & in_view);

   always_comb begin
      rdata = '0;
      case (sel)
         REG_DATA: rdata[DW-1:0] = data_view;
         REG_DIR:  rdata[DW-1:0] = dir_q;
         REG_HCS:  rdata = {flag, ctl_q, 2'b11};
         default:  rdata = '0;
      endcase
   end

   assign pin_out   = out_q;
   assign pin_oe    = dir_q;
   assign pullup_en = pu_q & ~dir_q;
   assign irq       = flag & ctl_q[IE_IDX];

   p_out_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr && sel == REG_DATA && dir_q == '1 |=> pin_out == $past(wdata[DW-1:0]));
   p_pullup_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr && sel == REG_DATA && dir_q == '0
      |=> pullup_en == $past(wdata[DW-1:0]) && $stable(pin_out));
   p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> flag);
endmodule

// File: tb/sim_hsp_port.sv
module sim_hsp_port;
   localparam int P    = 10;
   localparam int DW   = 8;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       rd = 1'b0, wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] pin_in = '0;
   logic       strobe_n = 1'b1;
   logic [7:0] pin_out, pin_oe, pullup_en;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit model_live = 0;

   hsp_port #(.DW(DW), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .strobe_n(strobe_n),
      .pin_out(pin_out), .pin_oe(pin_oe), .pullup_en(pullup_en), .irq(irq));

   always #(P/2) clk = ~clk;

   // behavioural reference model
   bit         m_flag, m_arm;
   logic [7:0] m_latch, m_dir, m_out, m_pu;
   logic [4:0] m_ctl;
   bit         sq[$];
   logic [7:0] pq[$];

   function automatic logic [7:0] m_live();
      return pq[pq.size()-SYNC];
   endfunction

   function automatic logic [7:0] m_rdata(logic [1:0] a);
      logic [7:0] inb;
      inb = m_flag ? m_latch : m_live();
      case (a)
         2'd0: return (m_dir & m_out) | (~m_dir & inb);
         2'd1: return m_dir;
         2'd2: return {m_flag, m_ctl, 2'b11};
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flag = 0; m_arm = 0; m_latch = '0; m_dir = '0; m_out = '0;
         m_pu = '0; m_ctl = '0;
         sq.delete(); pq.delete();
         for (int i = 0; i <= SYNC; i++) begin sq.push_back(1'b1); pq.push_back(8'h00); end
         model_live = 1;
      end else begin
         bit s_now, s_old, fall, acc;
         logic [7:0] live;
         s_now = sq[sq.size()-SYNC];
         s_old = sq[sq.size()-SYNC-1];
         live  = m_live();
         fall  = s_old && !s_now;
         acc   = (addr == 2'd0) && (rd || wr);
         if (fall) begin
            m_flag = 1; m_arm = 0; m_latch = live;
         end else if (m_arm && m_flag && acc) begin
            m_flag = 0; m_arm = 0;
         end else if (addr == 2'd2 && rd && m_flag) begin
            m_arm = 1;
         end
         if (wr) begin
            if (addr == 2'd0) begin
               m_out = (m_out & ~m_dir) | (wdata & m_dir);
               m_pu  = (m_pu & m_dir) | (wdata & ~m_dir);
            end else if (addr == 2'd1) m_dir = wdata;
            else if (addr == 2'd2) m_ctl = wdata[6:2];
         end
         sq.push_back(strobe_n); pq.push_back(pin_in);
         void'(sq.pop_front()); void'(pq.pop_front());
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the edge
   always @(posedge clk) begin
      #(P/4);
      if (rst_n && model_live && !done) begin
         chk("R9 model rdata", rdata, m_rdata(addr));
         chk("R7 model pin_out", pin_out, m_out);
         chk("R7 model pin_oe", pin_oe, m_dir);
         chk("R8 model pullup_en", pullup_en, m_pu & ~m_dir);
         chk("R10 model irq", {7'b0, irq}, {7'b0, m_flag & m_ctl[4]});
      end
   end

   task automatic idle();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic bus_rd(logic [1:0] a, output logic [7:0] v);
      addr = a; rd = 1'b1;
      #(P/4) v = rdata;
      @(posedge clk); @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic bus_wr(logic [1:0] a, logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk); @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic pulse(logic [7:0] pins);
      pin_in = pins; strobe_n = 1'b0;
      repeat (4) idle();
      strobe_n = 1'b1;
      repeat (3) idle();
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(P*50000);
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      idle();

      bus_rd(2'd2, v); chk("R1 status reset", v, 8'h03);
      bus_rd(2'd1, v); chk("R1 dir reset", v, 8'h00);
      chk("R1 irq reset", {7'b0, irq}, 8'h00);
      chk("R1 pin_oe reset", pin_oe, 8'h00);
      chk("R1 pullup reset", pullup_en, 8'h00);

      bus_wr(2'd2, 8'hFF); bus_rd(2'd2, v); chk("R2 ctrl all ones, flag not written", v, 8'h7F);
      bus_wr(2'd2, 8'h00); bus_rd(2'd2, v); chk("R2 ctrl cleared", v, 8'h03);
      bus_rd(2'd3, v); chk("R2 unused offset", v, 8'h00);

      bus_wr(2'd1, 8'hFF); bus_wr(2'd0, 8'hA5);
      chk("R7 pin_out", pin_out, 8'hA5);
      chk("R7 pin_oe", pin_oe, 8'hFF);
      bus_rd(2'd0, v); chk("R7 readback", v, 8'hA5);

      bus_wr(2'd1, 8'h00); bus_wr(2'd0, 8'h3C);
      chk("R8 pullup_en", pullup_en, 8'h3C);
      chk("R8 pin_out kept", pin_out, 8'hA5);
      pin_in = 8'h5A; repeat (3) idle();
      bus_rd(2'd0, v); chk("R9 live pins", v, 8'h5A);

      // first strobe: capture 0x96, then change the pins
      pulse(8'h96);
      pin_in = 8'h11; repeat (3) idle();
      bus_rd(2'd0, v); chk("R4 captured byte", v, 8'h96);
      bus_wr(2'd0, 8'h3C);
      bus_rd(2'd0, v); chk("R6 flag kept without status read", v, 8'h96);
      chk("R10 irq off while disabled", {7'b0, irq}, 8'h00);
      bus_wr(2'd2, 8'h40);
      chk("R10 irq on", {7'b0, irq}, 8'h01);
      bus_rd(2'd2, v); chk("R3 flag visible", v, 8'hC3);
      bus_rd(2'd0, v); chk("R9 latched while flag", v, 8'h96);
      bus_rd(2'd0, v); chk("R5 cleared by read, live pins", v, 8'h11);
      chk("R10 irq off after clear", {7'b0, irq}, 8'h00);
      bus_rd(2'd2, v); chk("R5 flag clear", v, 8'h43);

      // second strobe, cleared by a data write
      pulse(8'h22);
      bus_rd(2'd2, v); chk("R3 flag set again", v, 8'hC3);
      bus_wr(2'd0, 8'h0F);
      chk("R8 pullup from clearing write", pullup_en, 8'h0F);
      bus_rd(2'd2, v); chk("R5 cleared by write", v, 8'h43);

      // collision: new edge in the same cycle as the clearing access
      pulse(8'h44);
      bus_rd(2'd2, v); chk("R11 armed status", v, 8'hC3);
      pin_in = 8'h55; strobe_n = 1'b0;
      idle(); idle();
      bus_rd(2'd0, v); chk("R11 colliding read sees old capture", v, 8'h44);
      strobe_n = 1'b1; repeat (3) idle();
      bus_rd(2'd0, v); chk("R11 flag kept, new capture", v, 8'h55);
      bus_rd(2'd2, v); chk("R11 flag still set", v, 8'hC3);
      bus_rd(2'd0, v); chk("R5 clear after re-arm", v, 8'h55);
      bus_rd(2'd2, v); chk("R5 flag clear after collision", v, 8'h43);

      repeat (3) idle();
      finish_run();
   end
endmodule